// File: doc/BRIEF.md
# Sound Generator Host Register File

This block is the host side of a three-voice sound generator. A host drives an 8-bit data bus, a 5-bit register offset and separate write and read strobes. Writes land in per-voice registers (pitch, pulse width, control, envelope timing) and in shared filter and output-level registers. All decoded fields leave the block as parallel outputs that feed the oscillator, envelope and filter logic, which lie outside this block.

Four offsets are readable and return live values from outside: two paddle position bytes, the upper byte of the third voice's oscillator and the third voice's envelope level. Every other offset is write-only. A read there returns the most recent byte written to any offset. That byte has a limited lifetime: it is dropped to zero a fixed number of core cycles after the last write. Read data is registered and holds until the next read strobe.

Top module: `snd_regif`

## Requirements
- R1: Offsets 0x00–0x14 form three groups of seven registers at bases 0, 7 and 14 (voice 0, 1, 2). In each group, offset base+0 is the frequency low byte and base+1 the frequency high byte, so voice v's 16-bit frequency is {reg[base+1], reg[base+0]}.
- R2: Base+2 is the pulse-width low byte. Only bits 3:0 of base+3 are kept, as bits 11:8 of a 12-bit pulse width.
- R3: Base+4 is the control byte: bits 7:4 select the waveform, bit 3 is test, bit 2 is ring modulation, bit 1 is sync and bit 0 is gate.
- R4: Base+5 carries attack in bits 7:4 and decay in bits 3:0. Base+6 carries sustain in bits 7:4 and release in bits 3:0.
- R5: The 11-bit filter cutoff takes bits 2:0 of offset 0x15 as cutoff[2:0] and all of offset 0x16 as cutoff[10:3].
- R6: Offset 0x17 gives resonance in bits 7:4, external-input filtering in bit 3 and per-voice filter routing in bits 2:0 (bit v for voice v). Offset 0x18 gives voice-3 mute in bit 7, filter mode (high, band, low pass) in bits 6:4 and volume in bits 3:0.
- R7: A read strobe at offset 0x19, 0x1A, 0x1B or 0x1C returns paddle X, paddle Y, voice-3 oscillator byte or voice-3 envelope byte, sampled on the strobe edge and presented one clock later.
- R8: Every write, at any offset from 0x00 to 0x1F, loads a bus latch with the data byte and restarts its lifetime. A read at any offset other than 0x19–0x1C returns the bus latch.
- R9: With no further write, a read strobe sampled on the k-th clock edge after the write edge returns the byte for k ≤ LIFE and zero for k > LIFE (LIFE = 8192 by default).
- R10: A write on the very edge where the latch would expire wins: the new byte is held for a full fresh lifetime.
- R11: Writes to offsets 0x19–0x1F change no register output.
- R12: Active-low asynchronous reset clears every register, the bus latch, its lifetime and the read data.
- R13: Read data holds its value while no read strobe is present. A read that falls in the same cycle as a write returns the bus latch as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 5 | Register offset |
| wdata_i | input | 8 | Write data |
| pot_x_i | input | 8 | Paddle X value |
| pot_y_i | input | 8 | Paddle Y value |
| osc3_i | input | 8 | Voice-3 oscillator upper byte |
| env3_i | input | 8 | Voice-3 envelope level |
| rdata_o | output | 8 | Registered read data |
| freq_o | output | 48 | Voice frequencies, 16 bits per voice |
| pw_o | output | 36 | Pulse widths, 12 bits per voice |
| wave_o | output | 12 | Waveform selects, 4 bits per voice |
| test_o | output | 3 | Test bits |
| ring_o | output | 3 | Ring modulation enables |
| sync_o | output | 3 | Hard sync enables |
| gate_o | output | 3 | Gate bits |
| attack_o | output | 12 | Attack rates |
| decay_o | output | 12 | Decay rates |
| sustain_o | output | 12 | Sustain levels |
| release_o | output | 12 | Release rates |
| cutoff_o | output | 11 | Filter cutoff |
| reso_o | output | 4 | Filter resonance |
| ext_filt_o | output | 1 | Route external input through filter |
| filt_route_o | output | 3 | Per-voice filter routing |
| v3_off_o | output | 1 | Mute voice 3 at the output |
| fmode_o | output | 3 | Filter mode: high, band, low pass |
| volume_o | output | 4 | Master volume |

## Verification
Latch expiry and a fresh write can fall on the same edge. The bench idles for exactly LIFE−1 cycles after a write and then writes a new byte on the edge where the old one would clear. It then proves by reads at the edge boundary and a full lifetime later that the new byte survives and that the expiry count restarted. Read and write can also share a cycle. Random traffic that strobes both at once is judged against a bench model that takes its read value from the latch before the write updates it.

// File: rtl/snd_regif_pkg.sv
package snd_regif_pkg;
  localparam int NUM_VOICES = 3;
  localparam int VOICE_REGS = 7;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int FREQ_W = 16;
  localparam int PW_W = 12;
  localparam int CUT_W = 11;

  localparam logic [AW-1:0] OFS_CUT_LO = 5'h15;
  localparam logic [AW-1:0] OFS_CUT_HI = 5'h16;
  localparam logic [AW-1:0] OFS_ROUTE  = 5'h17;
  localparam logic [AW-1:0] OFS_MODE   = 5'h18;
  localparam logic [AW-1:0] OFS_POTX   = 5'h19;
  localparam logic [AW-1:0] OFS_POTY   = 5'h1A;
  localparam logic [AW-1:0] OFS_OSC3   = 5'h1B;
  localparam logic [AW-1:0] OFS_ENV3   = 5'h1C;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic [PW_W-1:0]   pw;
    logic [DW-1:0]     ctrl;
    logic [DW-1:0]     ad;
    logic [DW-1:0]     sr;
  } voice_regs_t;
endpackage

// File: rtl/snd_voice_regs.sv
module snd_voice_regs
  import snd_regif_pkg::*;
#(
  parameter int BASE = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output voice_regs_t   regs_o
);
  localparam int LAST = BASE + VOICE_REGS - 1;

  logic [AW:0] off;
  logic        hit;

  // unsigned wrap makes offsets below BASE fall out of range
  assign off = {1'b0, addr_i} - (AW+1)'(BASE);
  assign hit = wr_i && (off < (AW+1)'(VOICE_REGS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_o <= '0;
    end else if (hit) begin
      case (off[2:0])
        3'd0: regs_o.freq[7:0]       <= wdata_i;
        3'd1: regs_o.freq[15:8]      <= wdata_i;
        3'd2: regs_o.pw[7:0]         <= wdata_i;
        3'd3: regs_o.pw[PW_W-1:8]    <= wdata_i[PW_W-9:0];
        3'd4: regs_o.ctrl            <= wdata_i;
        3'd5: regs_o.ad              <= wdata_i;
        3'd6: regs_o.sr              <= wdata_i;
        default: ;
      endcase
    end
  end

  // R1
  freq_lo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(BASE)) |=> regs_o.freq[7:0] == $past(wdata_i));

  // R11
  foreign_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ((int'(addr_i) + 1 <= BASE) || (int'(addr_i) >= LAST + 1))) |=> $stable(regs_o));

  // R2
  pw_hi_trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(BASE + 3)) |=> regs_o.pw[PW_W-1:8] == $past(wdata_i[PW_W-9:0]));
endmodule

// File: rtl/snd_filt_regs.sv
module snd_filt_regs
  import snd_regif_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [CUT_W-1:0] cutoff_o,
  output logic [3:0]       reso_o,
  output logic             ext_filt_o,
  output logic [2:0]       filt_route_o,
  output logic             v3_off_o,
  output logic [2:0]       fmode_o,
  output logic [3:0]       volume_o
);
  logic [DW-1:0] route_q;
  logic [DW-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cutoff_o <= '0;
      route_q  <= '0;
      mode_q   <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_CUT_LO: cutoff_o[2:0]       <= wdata_i[2:0];
        OFS_CUT_HI: cutoff_o[CUT_W-1:3] <= wdata_i;
        OFS_ROUTE:  route_q             <= wdata_i;
        OFS_MODE:   mode_q              <= wdata_i;
        default: ;
      endcase
    end
  end

  assign reso_o       = route_q[7:4];
  assign ext_filt_o   = route_q[3];
  assign filt_route_o = route_q[2:0];
  assign v3_off_o     = mode_q[7];
  assign fmode_o      = mode_q[6:4];
  assign volume_o     = mode_q[3:0];

  // R5
  cut_hi_keeps_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CUT_HI) |=> $stable(cutoff_o[2:0]));

  // R5
  cut_lo_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CUT_LO) |=> $stable(cutoff_o[CUT_W-1:3]));

  // R11
  unmapped_filt_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i >= OFS_POTX) |=> ($stable(cutoff_o) && $stable(reso_o) && $stable(volume_o)));
endmodule

// File: rtl/snd_bus_latch.sv
module snd_bus_latch
  import snd_regif_pkg::*;
#(
  parameter int LIFE = 8192
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] latch_o
);
  localparam int CW = $clog2(LIFE + 1);

  logic [CW-1:0] ttl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      ttl_q   <= '0;
    end else if (wr_i) begin
      latch_o <= wdata_i;
      ttl_q   <= CW'(LIFE);
    end else if (ttl_q <= CW'(1)) begin
      latch_o <= '0;
      ttl_q   <= '0;
    end else begin
      ttl_q <= ttl_q - CW'(1);
    end
  end

  // R9
  ttl_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ttl_q <= CW'(LIFE));

  // R9
  dead_latch_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ttl_q == '0) |-> (latch_o == '0));

  // R8
  write_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (latch_o == $past(wdata_i) && ttl_q == CW'(LIFE)));

  // R9
  ttl_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && ttl_q > CW'(1)) |=> (ttl_q == $past(ttl_q) - CW'(1) && $stable(latch_o)));
endmodule

// File: rtl/snd_regif.sv
module snd_regif
  import snd_regif_pkg::*;
#(
  parameter int LIFE = 8192
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic                         rd_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic [DW-1:0]                pot_x_i,
  input  logic [DW-1:0]                pot_y_i,
  input  logic [DW-1:0]                osc3_i,
  input  logic [DW-1:0]                env3_i,
  output logic [DW-1:0]                rdata_o,
  output logic [NUM_VOICES*FREQ_W-1:0] freq_o,
  output logic [NUM_VOICES*PW_W-1:0]   pw_o,
  output logic [NUM_VOICES*4-1:0]      wave_o,
  output logic [NUM_VOICES-1:0]        test_o,
  output logic [NUM_VOICES-1:0]        ring_o,
  output logic [NUM_VOICES-1:0]        sync_o,
  output logic [NUM_VOICES-1:0]        gate_o,
  output logic [NUM_VOICES*4-1:0]      attack_o,
  output logic [NUM_VOICES*4-1:0]      decay_o,
  output logic [NUM_VOICES*4-1:0]      sustain_o,
  output logic [NUM_VOICES*4-1:0]      release_o,
  output logic [CUT_W-1:0]             cutoff_o,
  output logic [3:0]                   reso_o,
  output logic                         ext_filt_o,
  output logic [2:0]                   filt_route_o,
  output logic                         v3_off_o,
  output logic [2:0]                   fmode_o,
  output logic [3:0]                   volume_o
);
  voice_regs_t   vregs [NUM_VOICES];
  logic [DW-1:0] bus_latch;

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    snd_voice_regs #(.BASE(v * VOICE_REGS)) u_voice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .regs_o  (vregs[v])
    );
    assign freq_o[FREQ_W*v +: FREQ_W] = vregs[v].freq;
    assign pw_o[PW_W*v +: PW_W]       = vregs[v].pw;
    assign wave_o[4*v +: 4]           = vregs[v].ctrl[7:4];
    assign test_o[v]                  = vregs[v].ctrl[3];
    assign ring_o[v]                  = vregs[v].ctrl[2];
    assign sync_o[v]                  = vregs[v].ctrl[1];
    assign gate_o[v]                  = vregs[v].ctrl[0];
    assign attack_o[4*v +: 4]         = vregs[v].ad[7:4];
    assign decay_o[4*v +: 4]          = vregs[v].ad[3:0];
    assign sustain_o[4*v +: 4]        = vregs[v].sr[7:4];
    assign release_o[4*v +: 4]        = vregs[v].sr[3:0];
  end

  snd_filt_regs u_filt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .cutoff_o     (cutoff_o),
    .reso_o       (reso_o),
    .ext_filt_o   (ext_filt_o),
    .filt_route_o (filt_route_o),
    .v3_off_o     (v3_off_o),
    .fmode_o      (fmode_o),
    .volume_o     (volume_o)
  );

  snd_bus_latch #(.LIFE(LIFE)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .latch_o (bus_latch)
  );

  // read samples the latch before a same-cycle write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      case (addr_i)
        OFS_POTX: rdata_o <= pot_x_i;
        OFS_POTY: rdata_o <= pot_y_i;
        OFS_OSC3: rdata_o <= osc3_i;
        OFS_ENV3: rdata_o <= env3_i;
        default:  rdata_o <= bus_latch;
      endcase
    end
  end

  // R7
  live_potx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFS_POTX) |=> rdata_o == $past(pot_x_i));

  // R7
  live_env3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFS_ENV3) |=> rdata_o == $past(env3_i));

  // R13
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R11
  unmapped_voice_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i >= OFS_POTX) |=> ($stable(freq_o) && $stable(pw_o) && $stable(gate_o)));
endmodule

// File: tb/sim_snd_regif.sv
`timescale 1ns/1ps
module sim_snd_regif;
  import snd_regif_pkg::*;

  localparam int LIFE = 8192;
  localparam int NREG = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, pot_x = '0, pot_y = '0, osc3 = '0, env3 = '0;
  logic [7:0] rdata;
  logic [47:0] freq;
  logic [35:0] pw;
  logic [11:0] wave, attack, decay, sustain, release_r;
  logic [2:0]  test, ring, sync_b, gate, route, fmode;
  logic [10:0] cutoff;
  logic [3:0]  reso, vol;
  logic        ext_f, v3off;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] sh [NREG];
  logic [7:0] lat_m = '0;
  int ttl_m = 0;
  logic [7:0] last_rd = '0;

  always #4 clk = ~clk;

  snd_regif #(.LIFE(LIFE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .pot_x_i(pot_x), .pot_y_i(pot_y), .osc3_i(osc3), .env3_i(env3), .rdata_o(rdata),
    .freq_o(freq), .pw_o(pw), .wave_o(wave), .test_o(test), .ring_o(ring), .sync_o(sync_b),
    .gate_o(gate), .attack_o(attack), .decay_o(decay), .sustain_o(sustain),
    .release_o(release_r), .cutoff_o(cutoff), .reso_o(reso), .ext_filt_o(ext_f),
    .filt_route_o(route), .v3_off_o(v3off), .fmode_o(fmode), .volume_o(vol)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    case (a)
      5'h19: return pot_x;
      5'h1A: return pot_y;
      5'h1B: return osc3;
      5'h1C: return env3;
      default: return lat_m;
    endcase
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NREG; i++) sh[i] = '0;
    lat_m = '0; ttl_m = 0; last_rd = '0;
  endtask

  // called just after a falling edge
  task automatic step(input logic w, input logic r, input logic [4:0] a,
                      input logic [7:0] d, input string tag);
    logic [7:0] e;
    wr = w; rd = r; addr = a; wdata = d;
    pot_x = 8'($urandom); pot_y = 8'($urandom);
    osc3 = 8'($urandom); env3 = 8'($urandom);
    @(posedge clk);
    e = exp_read(a);
    if (w) begin
      if (int'(a) < NREG) sh[a] = d;
      lat_m = d; ttl_m = LIFE;
    end else if (ttl_m <= 1) begin
      lat_m = '0; ttl_m = 0;
    end else begin
      ttl_m--;
    end
    if (r) last_rd = e;
    @(negedge clk);
    if (r) chk(tag, 48'(rdata), 48'(e));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 5'd0, 8'd0, "");
  endtask

  task automatic check_all();
    for (int v = 0; v < NUM_VOICES; v++) begin
      int b = VOICE_REGS * v;
      chk("R1", 48'(freq[16*v +: 16]), 48'({sh[b+1], sh[b]}));
      chk("R2", 48'(pw[12*v +: 12]), 48'({sh[b+3][3:0], sh[b+2]}));
      chk("R3", 48'({wave[4*v +: 4], test[v], ring[v], sync_b[v], gate[v]}), 48'(sh[b+4]));
      chk("R4", 48'({attack[4*v +: 4], decay[4*v +: 4], sustain[4*v +: 4], release_r[4*v +: 4]}),
          48'({sh[b+5], sh[b+6]}));
    end
    chk("R5", 48'(cutoff), 48'({sh[22], sh[21][2:0]}));
    chk("R6", 48'({reso, ext_f, route}), 48'(sh[23]));
    chk("R6", 48'({v3off, fmode, vol}), 48'(sh[24]));
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] x, y;
    void'($urandom(32'd20240611));
    model_clear();
    repeat (3) @(negedge clk);
    // R12: reset state
    check_all();
    chk("R12", 48'(rdata), 48'(0));
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b1, 5'h03, 8'd0, "R12");

    // directed fill of every mapped register (R1-R6)
    for (int a = 0; a < NREG; a++) step(1'b1, 1'b0, 5'(a), 8'($urandom), "");
    check_all();
    // R2: upper nibble of pulse-width high dropped
    step(1'b1, 1'b0, 5'd10, 8'hF5, "");
    chk("R2", 48'(pw[23:12]), 48'(12'h500 | {4'h0, sh[9]}));
    // R5: low cutoff register keeps only 3 bits
    step(1'b1, 1'b0, 5'h15, 8'hFE, "");
    chk("R5", 48'(cutoff[2:0]), 48'(3'h6));

    // R11: unmapped writes refresh latch only
    for (int a = 25; a < 32; a++) begin
      step(1'b1, 1'b0, 5'(a), 8'($urandom), "");
      check_all();
    end
    // R8: write-only offset reads back the last byte (written to 0x1F)
    step(1'b0, 1'b1, 5'h00, 8'd0, "R8");
    step(1'b0, 1'b1, 5'h18, 8'd0, "R8");

    // R7: live reads
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 5'(5'h19 + 5'(i % 4)), 8'd0, "R7");

    // R13: hold and same-cycle read/write
    step(1'b1, 1'b0, 5'h02, 8'h3C, "");
    step(1'b1, 1'b1, 5'h05, 8'hA7, "R13");
    chk("R13", 48'(rdata), 48'(8'h3C));
    idle(3);
    chk("R13", 48'(rdata), 48'(last_rd));

    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      a = 5'($urandom % 32);
      step(($urandom % 3) == 0, ($urandom % 2) == 1, a, 8'($urandom),
           (a >= 5'h19 && a <= 5'h1C) ? "R7" : "R8");
      if (i % 60 == 59) check_all();
    end

    // R9: expiry boundary
    x = 8'h5A;
    step(1'b1, 1'b0, 5'h06, x, "");
    idle(LIFE - 1);
    step(1'b0, 1'b1, 5'h11, 8'd0, "R9");
    chk("R9", 48'(rdata), 48'(x));
    step(1'b0, 1'b1, 5'h11, 8'd0, "R9");
    chk("R9", 48'(rdata), 48'(0));

    // R10: write on the expiry edge restarts the lifetime
    step(1'b1, 1'b0, 5'h1E, x, "");
    idle(LIFE - 1);
    y = 8'hC3;
    step(1'b1, 1'b0, 5'h1F, y, "");
    idle(LIFE - 1);
    step(1'b0, 1'b1, 5'h04, 8'd0, "R10");
    chk("R10", 48'(rdata), 48'(y));
    step(1'b0, 1'b1, 5'h04, 8'd0, "R10");
    chk("R10", 48'(rdata), 48'(0));
    check_all();

    // R12: reset mid-run
    step(1'b1, 1'b0, 5'h08, 8'h77, "");
    step(1'b0, 1'b1, 5'h08, 8'd0, "R8");
    rst_n = 1'b0;
    #1;
    model_clear();
    check_all();
    chk("R12", 48'(rdata), 48'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b1, 5'h08, 8'd0, "R12");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule